// File: doc/BRIEF.md
# Three-Line Vectored Interrupt Mask Controller

This block is the interrupt front end of a small 8-bit processor core. Three request lines come in. Each line has its own mask bit, and one global enable gates acceptance for all three. The block tracks which lines are pending and picks the winner by fixed priority. It then offers the core a one-byte restart target for that line and holds the offer until the core acknowledges it. The top line is edge-triggered and latched. The two lower lines are level-triggered.

Software changes the masks through a one-byte set-mask write. The write applies only when its commit bit is set. A combinational read-mask byte reports the masks, the global enable and the three pending flags. The instruction decoder drives the global enable and disable strobes.

The grant state machine has two states:
- `GS_IDLE`: no offer is outstanding. The *arm* transition to `GS_OFFER` is taken on a clock edge where the global enable is set and at least one pending line is unmasked. The chosen line is frozen at that edge.
- `GS_OFFER`: the offer is presented. The *accept* transition back to `GS_IDLE` is taken on an edge with acknowledge high. The *withdraw* transition back to `GS_IDLE` is taken on an edge with the disable strobe high and acknowledge low.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all three masks read 1 (masked), the global enable reads 0, the latched top-line flag reads 0 and no offer is presented. With all request lines low, the read byte is 8'h07.
- R2: A write with `mask_wr_i`=1 and `mask_wdata_i[3]`=1 loads `mask_wdata_i[2:0]` into masks 2..0 from the next cycle on (1 = masked). A write with bit 3 = 0 leaves the masks unchanged.
- R3: `mask_rdata_o` is laid out as follows: [2:0] the masks of lines 2..0, [3] the global enable, [6:4] the pending flags of lines 2..0, and [7] always 0.
- R4: An enable strobe sets the global enable on the next cycle. A disable strobe clears it. When both strobes are high in the same cycle, disable wins.
- R5: Line 2 is edge-triggered. A 0-to-1 change sets its pending flag one cycle later. The flag stays set, whatever the line does afterwards, until line 2 is accepted. A line held high after acceptance does not set the flag again.
- R6: Lines 1 and 0 are level-triggered. Their pending flags follow the request inputs in the same cycle, with no register.
- R7: An offer (`irq_valid_o`=1) starts one cycle after an edge at which the global enable is 1 and some pending line is unmasked. No offer starts while the enable is 0 or while every pending line is masked.
- R8: When several unmasked lines are pending at the arm edge, line 2 wins over line 1, and line 1 wins over line 0.
- R9: While an offer is shown, `irq_vector_o` is 8'h3C for line 2, 8'h34 for line 1 and 8'h2C for line 0. It is 8'h00 when no offer is shown.
- R10: Acknowledge during an offer removes the offer and clears the global enable on the next cycle. If the offered line was line 2, it also clears that line's latched flag. Acknowledge with no offer shown has no effect.
- R11: The offered line stays fixed until acceptance, whatever the requests and masks do meanwhile. A disable strobe during an offer, without acknowledge, withdraws the offer on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Request lines 2..0 (line 2 edge-triggered) |
| en_strobe_i | input | 1 | Global enable strobe from the decoder |
| dis_strobe_i | input | 1 | Global disable strobe from the decoder |
| mask_wr_i | input | 1 | Set-mask write strobe |
| mask_wdata_i | input | 8 | Set-mask byte: [2:0] new masks, [3] commit |
| mask_rdata_o | output | 8 | Read-mask status byte |
| irq_valid_o | output | 1 | An interrupt offer is presented to the core |
| irq_vector_o | output | 8 | Restart target of the offered line |
| irq_ack_i | input | 1 | Core accepts the current offer |

## Verification
Each result has a fixed latency:
- The level-line pending bits change in the same cycle as their request.
- The latched bit, the masks and the global enable change one rising edge after their stimulus.
- An offer appears one edge after the arm condition holds. For a fresh top-line request that is two edges after the input rises.
- Acceptance or withdrawal removes the offer one edge after the strobe.

The bench drives inputs just after the falling edge, and it advances a behavioural model on each rising edge. It compares every output at the next falling edge, so each stimulus is judged exactly one edge later. The directed checks count those edges explicitly. For example, a mask write arriving in the edge where the state machine is idle delays the arm by one further edge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int unsigned IRQ_LINES    = 3;
    localparam int unsigned IRQ_IDX_W    = $clog2(IRQ_LINES);
    localparam logic [7:0]  IRQ_VEC_BASE = 8'h2C;
    localparam logic [7:0]  IRQ_VEC_STEP = 8'h08;

    typedef enum logic [0:0] {
        GS_IDLE  = 1'b0,
        GS_OFFER = 1'b1
    } grant_state_e;

endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         dis_i,
    input  logic         accept_i,
    input  logic         wr_i,
    input  logic [N:0]   wdata_i,
    output logic         gie_o,
    output logic [N-1:0] mask_o
);
    localparam int unsigned COMMIT_BIT = N;

    logic         gie_q;
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            mask_q <= '1;
        end else begin
            if (accept_i || dis_i) begin
                gie_q <= 1'b0;
            end else if (en_i) begin
                gie_q <= 1'b1;
            end
            if (wr_i && wdata_i[COMMIT_BIT]) begin
                mask_q <= wdata_i[N-1:0];
            end
        end
    end

    assign gie_o  = gie_q;
    assign mask_o = mask_q;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && wdata_i[COMMIT_BIT]) |=> $stable(mask_o)); // R2
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> !gie_o); // R4
    AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dis_i && !accept_i) |=> gie_o); // R4

endmodule

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
    parameter int unsigned N        = 3,
    parameter int unsigned EDGE_IDX = N - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         clr_edge_i,
    output logic [N-1:0] pend_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        if (g == EDGE_IDX) begin : g_edge
            logic prev_q;
            logic latch_q;
            logic rise;

            assign rise = req_i[g] && !prev_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q  <= 1'b0;
                    latch_q <= 1'b0;
                end else begin
                    prev_q <= req_i[g];
                    if (rise) begin
                        latch_q <= 1'b1;
                    end else if (clr_edge_i) begin
                        latch_q <= 1'b0;
                    end
                end
            end

            assign pend_o[g] = latch_q;

            AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_i[g]) |=> pend_o[g]); // R5
            AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o[g] && !clr_edge_i) |=> pend_o[g]); // R5
        end else begin : g_level
            assign pend_o[g] = req_i[g];
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
    import irq_vec_pkg::*;
#(
    parameter int unsigned N        = IRQ_LINES,
    parameter int unsigned IDX_W    = $clog2(N),
    parameter logic [7:0]  VEC_BASE = IRQ_VEC_BASE,
    parameter logic [7:0]  VEC_STEP = IRQ_VEC_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             ack_i,
    input  logic             dis_i,
    output logic             valid_o,
    output logic [7:0]       vector_o,
    output logic             accept_o,
    output logic [IDX_W-1:0] sel_o
);
    grant_state_e     state_q;
    logic [IDX_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (gie_i && any_i) begin
                        state_q <= GS_OFFER;
                        sel_q   <= idx_i;
                    end
                end
                GS_OFFER: begin
                    if (ack_i || dis_i) begin
                        state_q <= GS_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        valid_o  = 1'b0;
        vector_o = 8'h00;
        accept_o = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                valid_o = 1'b0;
            end
            GS_OFFER: begin
                valid_o  = 1'b1;
                vector_o = VEC_BASE + (VEC_STEP * 8'(sel_q));
                accept_o = ack_i;
            end
        endcase
    end

    assign sel_o = sel_q;

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i) |=> !valid_o); // R10
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i && !dis_i) |=> (valid_o && $stable(vector_o))); // R11
    AST_NO_ARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !gie_i) |=> !valid_o); // R7

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned N_LINES  = IRQ_LINES,
    parameter logic [7:0]  VEC_BASE = IRQ_VEC_BASE,
    parameter logic [7:0]  VEC_STEP = IRQ_VEC_STEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               en_strobe_i,
    input  logic               dis_strobe_i,
    input  logic               mask_wr_i,
    input  logic [7:0]         mask_wdata_i,
    output logic [7:0]         mask_rdata_o,
    output logic               irq_valid_o,
    output logic [7:0]         irq_vector_o,
    input  logic               irq_ack_i
);
    localparam int unsigned IDX_W    = $clog2(N_LINES);
    localparam int unsigned EDGE_IDX = N_LINES - 1;

    logic               gie;
    logic [N_LINES-1:0] mask;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] cand;
    logic               any_cand;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   sel;
    logic               accept;
    logic               clr_edge;
    logic               wdata_unused;

    assign wdata_unused = ^mask_wdata_i[7:N_LINES+1];

    irq_mask_regs #(.N(N_LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_strobe_i),
        .dis_i    (dis_strobe_i),
        .accept_i (accept),
        .wr_i     (mask_wr_i),
        .wdata_i  (mask_wdata_i[N_LINES:0]),
        .gie_o    (gie),
        .mask_o   (mask)
    );

    assign clr_edge = accept && (sel == IDX_W'(EDGE_IDX));

    irq_line_capture #(.N(N_LINES), .EDGE_IDX(EDGE_IDX)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .clr_edge_i (clr_edge),
        .pend_o     (pend)
    );

    assign cand = pend & ~mask;

    irq_prio_pick #(.N(N_LINES), .IDX_W(IDX_W)) u_pick (
        .cand_i (cand),
        .any_o  (any_cand),
        .idx_o  (pick_idx)
    );

    irq_grant_fsm #(
        .N        (N_LINES),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie_i    (gie),
        .any_i    (any_cand),
        .idx_i    (pick_idx),
        .ack_i    (irq_ack_i),
        .dis_i    (dis_strobe_i),
        .valid_o  (irq_valid_o),
        .vector_o (irq_vector_o),
        .accept_o (accept),
        .sel_o    (sel)
    );

    assign mask_rdata_o = 8'({pend, gie, mask});

    AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_ack_i) |=> !mask_rdata_o[3]); // R10
    AST_OFFER_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid_o) |-> $past(mask_rdata_o[3])); // R7
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid_o) && $past(mask_rdata_o[6]) && !$past(mask_rdata_o[2]))
        |-> (irq_vector_o == 8'h3C)); // R8
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (irq_vector_o == 8'h00)); // R9
    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rdata_o[7]); // R3

endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic       en = 1'b0;
    logic       dis = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       ack = 1'b0;
    logic [7:0] rdata;
    logic       valid;
    logic [7:0] vec;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .en_strobe_i  (en),
        .dis_strobe_i (dis),
        .mask_wr_i    (wr),
        .mask_wdata_i (wdata),
        .mask_rdata_o (rdata),
        .irq_valid_o  (valid),
        .irq_vector_o (vec),
        .irq_ack_i    (ack)
    );

    // behavioural reference
    bit       m_gie, m_p2, m_prev2, m_off;
    bit [2:0] m_mask;
    int       m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gie <= 0; m_p2 <= 0; m_prev2 <= 0; m_off <= 0;
            m_mask <= 3'b111; m_sel <= 0;
        end else begin
            bit rise, accepted;
            bit [2:0] c;
            rise = req[2] && !m_prev2;
            accepted = m_off && ack;
            m_prev2 <= req[2];
            if (rise) m_p2 <= 1;
            else if (accepted && m_sel == 2) m_p2 <= 0;
            if (wr && wdata[3]) m_mask <= wdata[2:0];
            if (accepted || dis) m_gie <= 0;
            else if (en) m_gie <= 1;
            if (!m_off) begin
                c = {m_p2, req[1], req[0]} & ~m_mask;
                if (m_gie && c != 0) begin
                    m_off <= 1;
                    m_sel <= c[2] ? 2 : (c[1] ? 1 : 0);
                end
            end else if (ack || dis) begin
                m_off <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        logic [7:0] e_rd, e_vec;
        @(negedge clk);
        e_rd = {1'b0, m_p2, req[1], req[0], m_gie, m_mask};
        e_vec = m_off ? 8'(8'h2C + 8 * m_sel) : 8'h00;
        chk("R3 read byte", rdata, e_rd);
        chk("R7 offer valid", {7'd0, valid}, {7'd0, m_off});
        chk("R9 vector", vec, e_vec);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 reset byte", rdata, 8'h07);
        chk("R1 reset no offer", {7'd0, valid}, 8'h00);

        wr = 1; wdata = 8'h05; tick(); wr = 0;
        chk("R2 commit clear ignored", {5'd0, rdata[2:0]}, 8'h07);
        wr = 1; wdata = 8'h0A; tick(); wr = 0;
        chk("R2 masks loaded", {5'd0, rdata[2:0]}, 8'h02);

        en = 1; tick(); en = 0;
        chk("R4 enable", {7'd0, rdata[3]}, 8'h01);
        en = 1; dis = 1; tick(); en = 0; dis = 0;
        chk("R4 disable wins", {7'd0, rdata[3]}, 8'h00);
        en = 1; tick(); en = 0;

        req = 3'b010; #1;
        chk("R6 level same cycle", {7'd0, rdata[5]}, 8'h01);
        tick(); tick();
        chk("R7 masked no offer", {7'd0, valid}, 8'h00);

        wr = 1; wdata = 8'h08; tick(); wr = 0;
        tick();
        chk("R7 offer after unmask", {7'd0, valid}, 8'h01);
        chk("R9 line1 vector", vec, 8'h34);

        req = 3'b111; tick(); tick();
        chk("R11 selection frozen", vec, 8'h34);
        chk("R5 top latched", {7'd0, rdata[6]}, 8'h01);

        ack = 1; tick(); ack = 0;
        chk("R10 offer removed", {7'd0, valid}, 8'h00);
        chk("R10 enable cleared", {7'd0, rdata[3]}, 8'h00);

        en = 1; tick(); en = 0; tick();
        chk("R8 top line wins", vec, 8'h3C);
        ack = 1; tick(); ack = 0;
        chk("R5 cleared no relatch", {7'd0, rdata[6]}, 8'h00);

        req = 3'b001; en = 1; tick(); en = 0; tick();
        chk("R9 line0 vector", vec, 8'h2C);
        dis = 1; tick(); dis = 0;
        chk("R11 withdraw", {7'd0, valid}, 8'h00);
        ack = 1; tick(); ack = 0;
        chk("R10 stray ack ignored", rdata, 8'h10);
        req = 3'b000; #1;
        chk("R6 level drop", {7'd0, rdata[4]}, 8'h00);

        begin
            logic [15:0] lf = 16'hACE1;
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                req   = lf[2:0];
                en    = lf[3] & lf[4];
                dis   = lf[5] & lf[6] & lf[7];
                ack   = lf[8];
                wr    = lf[9] & lf[10];
                wdata = lf[15:8];
                tick();
            end
            req = 0; en = 0; dis = 0; ack = 0; wr = 0;
        end
        tick();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1..: got hung expected completion");
            finish_run();
        end
    end

endmodule